// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a processor core that completes one instruction on every rising clock edge. It implements eleven instructions from a classic three-format 32-bit load/store instruction set. Register operations are add, subtract and signed set-less-than. The immediate operations are add-immediate and set-less-than-immediate. It also has word load and word store, branch on equal and branch on not-equal, an absolute jump and a jump through a register. A program counter, a decoder, a 32-entry register file and a small ALU sit around two word-addressed memories inside the block, one for instructions and one for data.

Both memories are filled through a preload port. Loading normally happens while reset is held, and a preload write to the data memory takes priority over a store. The core has no separate trace logic. It shows its architectural events as output ports: the current program counter, each register-file write (index and value), each data-memory write (byte address and value) and an illegal-instruction flag. Anything outside the block can follow execution from these ports alone.

Top module: `sc_core32`

## Requirements
- R1: A synchronous active-high reset sets `pc_o` to 0. While reset is high, `rf_we_o`, `dm_we_o` and `illegal_o` stay low.
- R2: When op = 0, funct 32 writes rs+rt to rd, funct 34 writes rs-rt and funct 42 writes 1 if rs < rt as signed numbers (0 otherwise). Results wrap modulo 2^32 and overflow raises nothing.
- R3: Opcode 8 writes rs + sext(imm16) to rt. Opcode 10 writes 1 to rt if rs < sext(imm16) as signed numbers, and 0 otherwise.
- R4: Opcode 35 loads into rt the data word at byte address rs + sext(imm16). Opcode 43 stores rt there and shows the address on `dm_addr_o` with `dm_we_o` high. The word index is address bits [MEM_AW+1:2].
- R5: Opcode 4 (rs equal to rt) and opcode 5 (rs not equal to rt) set the next PC to PC+4 + (sext(imm16) << 2) when their condition holds, and to PC+4 otherwise. Neither writes a register.
- R6: Opcode 2 sets the next PC to {PC+4[31:28], target26, 2'b00}. With op = 0, funct 8 sets the next PC to the value of rs.
- R7: Register 0 always reads as zero. An instruction whose destination is register 0 leaves `rf_we_o` low.
- R8: An instruction that reads the register it writes sees the value the register held before that instruction.
- R9: Any other opcode, or any other funct under op = 0, writes nothing, raises `illegal_o` in the cycle it executes, and advances the PC by 4.
- R10: A preload write stores `pl_data` at word index `pl_addr` of the instruction memory when `pl_dmem` = 0, and of the data memory when `pl_dmem` = 1.
- R11: Every instruction that is not a taken branch, a jump or a register jump advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pl_we | input | 1 | Preload write strobe |
| pl_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| pl_addr | input | MEM_AW | Preload word index |
| pl_data | input | 32 | Preload word |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| illegal_o | output | 1 | Current instruction is undefined |
| rf_we_o | output | 1 | Register write committed at the next edge |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write value |
| dm_we_o | output | 1 | Data-memory store committed at the next edge |
| dm_addr_o | output | 32 | Effective byte address of the load or store |
| dm_wdata_o | output | 32 | Store value |

## Verification
One program covers the whole instruction mix. Operands are chosen so each result separates the right rule from a near miss. Signed compares use a negative against a positive, in both orders, so an unsigned compare would give the opposite answer, and set-less-than is also tried on equal operands. Stores and loads use a positive and a negative offset from the same base. Each branch kind is exercised both taken and not taken, and the taken branches skip instructions that would leave a visible register write if the target were off by one word. A forward jump, a register jump, two undefined encodings and a self-loop follow. A second program, preloaded during reset, loads a value placed by preload and doubles it in place. This checks the read-before-write order and the silent wrap on overflow.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_JUMP    = 6'd2;
  localparam logic [5:0] OPC_BREQ    = 6'd4;
  localparam logic [5:0] OPC_BRNE    = 6'd5;
  localparam logic [5:0] OPC_ADDIMM  = 6'd8;
  localparam logic [5:0] OPC_LTIMM   = 6'd10;
  localparam logic [5:0] OPC_LOADW   = 6'd35;
  localparam logic [5:0] OPC_STOREW  = 6'd43;

  localparam logic [5:0] FN_JREG = 6'd8;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_SLT  = 6'd42;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_SLT = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;
    logic    use_imm;
    alu_op_e alu_op;
    logic    mem_read;
    logic    mem_write;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
    logic    jump_reg;
    logic    illegal;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_SLT: return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [15:0] off);
    return pc4 + {sext16(off)[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                input logic [25:0] tgt);
    return {pc4[XLEN-1:XLEN-4], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OPC_SPECIAL: begin
        case (funct)
          FN_ADD: begin
            ctrl.reg_write = 1'b1;
            ctrl.dst_rd    = 1'b1;
            ctrl.alu_op    = ALU_ADD;
          end
          FN_SUB: begin
            ctrl.reg_write = 1'b1;
            ctrl.dst_rd    = 1'b1;
            ctrl.alu_op    = ALU_SUB;
          end
          FN_SLT: begin
            ctrl.reg_write = 1'b1;
            ctrl.dst_rd    = 1'b1;
            ctrl.alu_op    = ALU_SLT;
          end
          FN_JREG: ctrl.jump_reg = 1'b1;
          default: ctrl.illegal  = 1'b1;
        endcase
      end
      OPC_ADDIMM: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.alu_op    = ALU_ADD;
      end
      OPC_LTIMM: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.alu_op    = ALU_SLT;
      end
      OPC_LOADW: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.mem_read  = 1'b1;
      end
      OPC_STOREW: begin
        ctrl.use_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OPC_BREQ: begin
        ctrl.br_eq  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OPC_BRNE: begin
        ctrl.br_ne  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OPC_JUMP: ctrl.jump    = 1'b1;
      default:  ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    y    = alu_eval(op, a, b);
    zero = (y == '0);
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (we && (waddr != '0) && (waddr == AW'(i))) regs[i] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_core32.sv
module sc_core32
  import sc_core_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int NREG   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pl_we,
  input  logic              pl_dmem,
  input  logic [MEM_AW-1:0] pl_addr,
  input  logic [31:0]       pl_data,
  output logic [31:0]       pc_o,
  output logic              illegal_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [31:0]       rf_wdata_o,
  output logic              dm_we_o,
  output logic [31:0]       dm_addr_o,
  output logic [31:0]       dm_wdata_o
);

  localparam int MEM_WORDS = 1 << MEM_AW;
  localparam int IDX_HI    = MEM_AW + 1;

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next;
  logic [XLEN-1:0] instr;
  logic [RIDX-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
  logic [15:0]     imm16;
  ctrl_t           ctrl;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, ld_val, wb_val;
  logic            alu_zero;

  // named control events, also observed by the checker
  logic br_taken, jmp_abs, jmp_reg, seq_step;

  assign instr  = imem[pc_q[IDX_HI:2]];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign imm16  = instr[15:0];

  sc_decoder u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk   (clk),
    .we    (rf_we_o),
    .waddr (dst_idx),
    .wdata (wb_val),
    .ra1   (rs_idx),
    .rd1   (rs_val),
    .ra2   (rt_idx),
    .rd2   (rt_val)
  );

  assign alu_b = ctrl.use_imm ? sext16(imm16) : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign ld_val  = dmem[alu_y[IDX_HI:2]];
  assign wb_val  = ctrl.mem_read ? ld_val : alu_y;
  assign dst_idx = ctrl.dst_rd ? rd_idx : rt_idx;

  assign br_taken = (ctrl.br_eq & alu_zero) | (ctrl.br_ne & ~alu_zero);
  assign jmp_abs  = ctrl.jump;
  assign jmp_reg  = ctrl.jump_reg;
  assign seq_step = ~br_taken & ~jmp_abs & ~jmp_reg;

  assign pc_plus4 = pc_q + 32'd4;

  always_comb begin
    if (jmp_reg)       pc_next = rs_val;
    else if (jmp_abs)  pc_next = jump_dest(pc_plus4, instr[25:0]);
    else if (br_taken) pc_next = branch_dest(pc_plus4, imm16);
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (pl_we && !pl_dmem) imem[pl_addr] <= pl_data;
  end

  always_ff @(posedge clk) begin
    if (pl_we && pl_dmem) dmem[pl_addr] <= pl_data;
    else if (dm_we_o)     dmem[alu_y[IDX_HI:2]] <= rt_val;
  end

  assign pc_o       = pc_q;
  assign illegal_o  = ctrl.illegal & ~rst;
  assign rf_we_o    = ctrl.reg_write & ~rst & (dst_idx != '0);
  assign rf_waddr_o = dst_idx;
  assign rf_wdata_o = wb_val;
  assign dm_we_o    = ctrl.mem_write & ~rst;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

endmodule

// File: rtl/sc_core32_chk.sv
module sc_core32_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic        br_taken,
  input logic        jmp_abs,
  input logic        jmp_reg,
  input logic        seq_step,
  input logic        illegal,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic        dm_we
);

  AST_RESET_PC_ZERO: assert property (@(posedge clk)
    rst |=> (pc == 32'd0)); // R1

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    seq_step |=> (pc == $past(pc) + 32'd4)); // R11

  AST_BRANCH_DEST: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc == $past(pc) + 32'd4 +
                  {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00})); // R5

  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (rst)
    jmp_abs |=> (pc == {$past(pc[31:28] + {3'b0, &pc[27:2]}),
                        $past(instr[25:0]), 2'b00})); // R6

  AST_JREG_DEST: assert property (@(posedge clk) disable iff (rst)
    jmp_reg |=> (pc == $past(rs_val))); // R6

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rf_we && !dm_we)); // R9

  AST_ILLEGAL_STEP: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (pc == $past(pc) + 32'd4)); // R9

  AST_NO_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr != 5'd0)); // R7

endmodule

bind sc_core32 sc_core32_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_q),
  .instr    (instr),
  .rs_val   (rs_val),
  .br_taken (br_taken),
  .jmp_abs  (jmp_abs),
  .jmp_reg  (jmp_reg),
  .seq_step (seq_step),
  .illegal  (illegal_o),
  .rf_we    (rf_we_o),
  .rf_waddr (rf_waddr_o),
  .dm_we    (dm_we_o)
);

// File: tb/sim_sc_core32.sv
module sim_sc_core32;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 6;
  localparam int NVEC       = 27;

  // vector: {req[3:0], pc[31:0], kind[1:0], addr[31:0], data[31:0], illegal}
  // kind 0 = no write, 1 = register write (addr = index), 2 = store (addr = byte address)
  localparam logic [102:0] VEC [NVEC] = '{
    {4'd3,  32'h00, 2'd1, 32'd1,  32'd5,        1'b0}, // R3 addi positive
    {4'd3,  32'h04, 2'd1, 32'd2,  32'hFFFFFFFD, 1'b0}, // R3 addi negative
    {4'd2,  32'h08, 2'd1, 32'd3,  32'd2,        1'b0}, // R2 add
    {4'd2,  32'h0C, 2'd1, 32'd4,  32'hFFFFFFF8, 1'b0}, // R2 sub
    {4'd2,  32'h10, 2'd1, 32'd5,  32'd1,        1'b0}, // R2 slt neg<pos
    {4'd2,  32'h14, 2'd1, 32'd6,  32'd0,        1'b0}, // R2 slt pos<neg false
    {4'd3,  32'h18, 2'd1, 32'd7,  32'd1,        1'b0}, // R3 slti -3<-2
    {4'd3,  32'h1C, 2'd1, 32'd8,  32'd0,        1'b0}, // R3 slti equal
    {4'd3,  32'h20, 2'd1, 32'd9,  32'h00007FFF, 1'b0}, // R3 largest immediate
    {4'd11, 32'h24, 2'd1, 32'd10, 32'd16,       1'b0}, // R11 base register
    {4'd4,  32'h28, 2'd2, 32'd24, 32'hFFFFFFF8, 1'b0}, // R4 store positive offset
    {4'd4,  32'h2C, 2'd2, 32'd12, 32'd5,        1'b0}, // R4 store negative offset
    {4'd4,  32'h30, 2'd1, 32'd11, 32'hFFFFFFF8, 1'b0}, // R4 load from zero base
    {4'd4,  32'h34, 2'd1, 32'd12, 32'd5,        1'b0}, // R4 load negative offset
    {4'd7,  32'h38, 2'd0, 32'd0,  32'd0,        1'b0}, // R7 destination r0 not written
    {4'd7,  32'h3C, 2'd1, 32'd13, 32'd0,        1'b0}, // R7 r0 reads zero
    {4'd5,  32'h40, 2'd0, 32'd0,  32'd0,        1'b0}, // R5 beq taken
    {4'd5,  32'h4C, 2'd0, 32'd0,  32'd0,        1'b0}, // R5 bne not taken
    {4'd5,  32'h50, 2'd0, 32'd0,  32'd0,        1'b0}, // R5 bne taken
    {4'd5,  32'h60, 2'd0, 32'd0,  32'd0,        1'b0}, // R5 beq not taken
    {4'd6,  32'h64, 2'd0, 32'd0,  32'd0,        1'b0}, // R6 jump
    {4'd6,  32'h80, 2'd1, 32'd15, 32'h000000B0, 1'b0}, // R6 jump landed
    {4'd6,  32'h84, 2'd0, 32'd0,  32'd0,        1'b0}, // R6 register jump
    {4'd9,  32'hB0, 2'd0, 32'd0,  32'd0,        1'b1}, // R9 unknown opcode
    {4'd9,  32'hB4, 2'd0, 32'd0,  32'd0,        1'b1}, // R9 unknown funct
    {4'd5,  32'hB8, 2'd0, 32'd0,  32'd0,        1'b0}, // R5 backward self branch
    {4'd5,  32'hB8, 2'd0, 32'd0,  32'd0,        1'b0}  // R5 loop holds
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pl_we = 1'b0;
  logic              pl_dmem = 1'b0;
  logic [MEM_AW-1:0] pl_addr = '0;
  logic [31:0]       pl_data = '0;
  logic [31:0]       pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic              illegal_o, rf_we_o, dm_we_o;
  logic [4:0]        rf_waddr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core32 #(.MEM_AW(MEM_AW)) u0 (
    .clk(clk), .rst(rst), .pl_we(pl_we), .pl_dmem(pl_dmem),
    .pl_addr(pl_addr), .pl_data(pl_data), .pc_o(pc_o),
    .illegal_o(illegal_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
    .dm_wdata_o(dm_wdata_o)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic preload(input logic dsel, input int idx, input logic [31:0] w);
    @(negedge clk);
    pl_we = 1'b1; pl_dmem = dsel; pl_addr = MEM_AW'(idx); pl_data = w;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input logic [98:0] act, input logic [98:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [98:0] observe();
    logic [1:0]  k;
    logic [31:0] a, d;
    k = 2'd0; a = '0; d = '0;
    if (rf_we_o) begin k = 2'd1; a = {27'd0, rf_waddr_o}; d = rf_wdata_o; end
    else if (dm_we_o) begin k = 2'd2; a = dm_addr_o; d = dm_wdata_o; end
    return {pc_o, k, a, d, illegal_o};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [98:0] obs;
    // R10: memories filled through the preload port while reset is held
    for (int i = 0; i < (1 << MEM_AW); i++) preload(1'b0, i, 32'h00000020);
    preload(1'b0, 0,  enc_i(8, 0, 1, 16'd5));
    preload(1'b0, 1,  enc_i(8, 0, 2, 16'hFFFD));
    preload(1'b0, 2,  enc_r(1, 2, 3, 32));
    preload(1'b0, 3,  enc_r(2, 1, 4, 34));
    preload(1'b0, 4,  enc_r(2, 1, 5, 42));
    preload(1'b0, 5,  enc_r(1, 2, 6, 42));
    preload(1'b0, 6,  enc_i(10, 2, 7, 16'hFFFE));
    preload(1'b0, 7,  enc_i(10, 1, 8, 16'd5));
    preload(1'b0, 8,  enc_i(8, 0, 9, 16'h7FFF));
    preload(1'b0, 9,  enc_i(8, 0, 10, 16'd16));
    preload(1'b0, 10, enc_i(43, 10, 4, 16'd8));
    preload(1'b0, 11, enc_i(43, 10, 1, 16'hFFFC));
    preload(1'b0, 12, enc_i(35, 0, 11, 16'd24));
    preload(1'b0, 13, enc_i(35, 10, 12, 16'hFFFC));
    preload(1'b0, 14, enc_r(1, 1, 0, 32));
    preload(1'b0, 15, enc_r(0, 0, 13, 32));
    preload(1'b0, 16, enc_i(4, 1, 12, 16'd2));
    preload(1'b0, 17, enc_i(8, 0, 14, 16'd1));
    preload(1'b0, 18, enc_i(8, 0, 14, 16'd2));
    preload(1'b0, 19, enc_i(5, 1, 12, 16'd5));
    preload(1'b0, 20, enc_i(5, 1, 2, 16'd3));
    for (int i = 21; i < 24; i++) preload(1'b0, i, enc_i(8, 0, 14, 16'd3));
    preload(1'b0, 24, enc_i(4, 1, 2, 16'd1));
    preload(1'b0, 25, enc_j(26'h20));
    preload(1'b0, 26, enc_i(8, 0, 14, 16'd4));
    preload(1'b0, 32, enc_i(8, 0, 15, 16'h00B0));
    preload(1'b0, 33, enc_r(15, 0, 0, 8));
    preload(1'b0, 44, 32'hFC000000);
    preload(1'b0, 45, enc_r(1, 1, 16, 0));
    preload(1'b0, 46, enc_i(4, 0, 0, 16'hFFFF));

    // R1: reset state
    #1;
    obs = observe();
    check(pc_o == 32'd0 && !rf_we_o && !dm_we_o && !illegal_o, "R1", "reset state",
          obs, 99'd0);

    rst = 1'b0;
    #1;
    for (int s = 0; s < NVEC; s++) begin
      obs = observe();
      check(obs == VEC[s][98:0], $sformatf("R%0d", VEC[s][102:99]),
            $sformatf("step %0d", s), obs, VEC[s][98:0]);
      @(negedge clk);
      #1;
    end

    // R1: reset asserted mid-run returns the PC to zero
    rst = 1'b1;
    @(negedge clk);
    #1;
    obs = observe();
    check(pc_o == 32'd0 && !rf_we_o && !dm_we_o, "R1", "mid-run reset", obs, 99'd0);

    // R10, R4: second program placed through preload while in reset
    preload(1'b1, 5, 32'hCAFEF00D);
    preload(1'b0, 0, enc_i(35, 0, 16, 16'd20));
    preload(1'b0, 1, enc_r(16, 16, 16, 32));
    preload(1'b0, 2, enc_i(4, 0, 0, 16'hFFFF));
    rst = 1'b0;
    #1;
    obs = observe();
    check(obs == {32'h0, 2'd1, 32'd16, 32'hCAFEF00D, 1'b0}, "R10", "preloaded data loaded",
          obs, {32'h0, 2'd1, 32'd16, 32'hCAFEF00D, 1'b0});
    @(negedge clk);
    #1;
    // R8 reads old value of its own destination; R2 wraps on overflow
    obs = observe();
    check(obs == {32'h4, 2'd1, 32'd16, 32'h95FDE01A, 1'b0}, "R8", "self add old value",
          obs, {32'h4, 2'd1, 32'd16, 32'h95FDE01A, 1'b0});
    @(negedge clk);
    #1;
    obs = observe();
    check(obs == {32'h8, 2'd0, 32'd0, 32'd0, 1'b0}, "R5", "self loop",
          obs, {32'h8, 2'd0, 32'd0, 32'd0, 1'b0});
    @(negedge clk);
    #1;
    obs = observe();
    check(pc_o == 32'h8, "R5", "self loop holds", obs, {32'h8, 67'd0});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule